// File: doc/BRIEF.md
# Byte-Serial Variable-Length Instruction Splitter

This block cuts a stream of instruction bytes, one byte per valid cycle, into whole instructions of variable length. It walks each instruction through prefix, opcode, ModRM, SIB, displacement and immediate phases. Along the way it gathers the REX byte, the escape count, the opcode, ModRM, SIB, the displacement value and the immediate value into an output record. When the last byte of an instruction has been taken, it raises a one-cycle ready flag and reports the length in bytes.

The opcode tables are not inside the block. A small lookup beside it looks at the incoming byte and at the escape count the block presents on `tbl_map`. It answers in the same cycle whether a ModRM byte follows and which immediate kind the opcode takes. The block turns that kind into a byte count, using the effective operand size. A dedicated idle phase sits before every instruction. The first byte of an instruction wipes all collected fields, latches the byte's address as the start, and is decoded in that same cycle.

Top module: `insn_splitter`

## Requirements
- R1: After reset, `rdy` is 0 and every record output is 0. The first byte of each instruction clears REX, escape count, opcode, ModRM, SIB, displacement, immediate and the 0x66 flag, and is itself decoded in that cycle. A field that an instruction lacks reads 0.
- R2: A byte in 0x40..0x4F is stored in `ins_rex`, and the last such byte wins. The legacy prefixes 0xF0, 0xF2, 0xF3, 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66 and 0x67 are skipped. Neither kind counts as the opcode.
- R3: Byte 0x0F in the opcode position raises the escape count on `tbl_map`, up to MAX_ESC (default 2). After that limit, 0x0F is taken as the opcode. The opcode byte goes to `ins_opc`. The next phase is ModRM when `tbl_modrm` is 1. Otherwise it is immediate when the immediate size is nonzero. Otherwise the instruction is complete.
- R4: The ModRM byte is always consumed, with mod = bits 7:6 and rm = bits 2:0. A SIB byte follows when mod is not 3 and rm is 4. The displacement is 1 byte for mod 1, and 4 bytes for mod 2 or for mod 0 with rm 5. A SIB base (bits 2:0) of 5 with mod 0 also gives 4 bytes.
- R5: `ins_osz` is 2 (64-bit) when REX bit 3 is set. Otherwise it is 0 (16-bit) when 0x66 was seen. Otherwise it is 1 (32-bit).
- R6: The immediate byte count for `tbl_itype` codes 0..9 is as follows. Codes 0..5 give 0, 1, 2, 4, 8 and 16 bytes. Code 6 gives 2, 4 or 8 bytes for sizes 16, 32 and 64. Code 7 gives 2, 4 or 4. Code 8 gives 3. Code 9 gives 4, 6 or 0. Codes 10..15 give 0.
- R7: Displacement and immediate are assembled little-endian: byte k lands in bits 8k+7..8k.
- R8: `rdy` is high for one cycle, the cycle after the clock edge that takes an instruction's final byte. With it, `ins_len` equals the final byte's address + 1 − the first byte's address, modulo 2^AW.
- R9: While `byte_vld` is 0, the phase and all fields hold and `rdy` stays 0.
- R10: The immediate phase takes exactly the required number of bytes, and `rdy` never rises before the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A byte is offered this cycle |
| byte_in | input | 8 | Instruction byte |
| byte_pc | input | AW | Address of `byte_in` |
| tbl_map | output | MW | Escape count for the opcode lookup |
| tbl_modrm | input | 1 | Lookup answer: the opcode takes ModRM |
| tbl_itype | input | 4 | Lookup answer: immediate kind code |
| rdy | output | 1 | Instruction complete, record valid |
| ins_len | output | LW | Instruction length in bytes |
| ins_rex | output | 8 | REX byte, 0 if none |
| ins_map | output | MW | Escape count of the opcode |
| ins_opc | output | 8 | Opcode byte |
| ins_modrm | output | 8 | ModRM byte |
| ins_sib | output | 8 | SIB byte |
| ins_disp | output | 8*DISP_BYTES | Displacement value |
| ins_imm | output | 8*IMM_BYTES | Immediate value |
| ins_osz | output | 2 | Operand size: 0=16, 1=32, 2=64 |

## Verification
Some properties are checked on every cycle. A ready flag must follow a consumed byte. An idle input must freeze the phase and keep ready low. The displacement and immediate byte counters must match the sizes the decoder chose whenever an instruction completes. The displacement size must be 0, 1 or 4. The accumulators must never write beyond their width. The bench scenarios are needed for the rest: the ModRM/SIB path choice, the operand-size priority, the immediate size table, byte ordering, the escape limit, field wiping between instructions, and length arithmetic across an address wrap.

// File: rtl/ispl_pkg.sv
package ispl_pkg;

   typedef enum logic [2:0] {
      S_RST, S_PFX, S_OPC, S_MRM, S_SIB, S_DSP, S_IMM
   } phase_e;

   typedef enum logic [1:0] {
      OSZ_16 = 2'd0,
      OSZ_32 = 2'd1,
      OSZ_64 = 2'd2
   } osz_e;

   localparam logic [7:0] BYTE_ESC = 8'h0F;
   localparam logic [7:0] BYTE_OSZ = 8'h66;

   function automatic logic is_rex(input logic [7:0] b);
      return b[7:4] == 4'h4;
   endfunction

   function automatic logic is_legacy(input logic [7:0] b);
      case (b)
         8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36,
         8'h3E, 8'h64, 8'h65, 8'h66, 8'h67: return 1'b1;
         default:                            return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ispl_imm_size.sv
module ispl_imm_size
   import ispl_pkg::*;
#(
   parameter int ICW = 5
)(
   input  osz_e             osz,
   input  logic [3:0]       itype,
   output logic [ICW-1:0]   nbytes
);

   logic [4:0] n;

   // R6: byte count per kind code and operand size
   always_comb begin
      unique case (itype)
         4'd1:    n = 5'd1;
         4'd2:    n = 5'd2;
         4'd3:    n = 5'd4;
         4'd4:    n = 5'd8;
         4'd5:    n = 5'd16;
         4'd6:    n = (osz == OSZ_16) ? 5'd2 : (osz == OSZ_32) ? 5'd4 : 5'd8;
         4'd7:    n = (osz == OSZ_16) ? 5'd2 : 5'd4;
         4'd8:    n = 5'd3;
         4'd9:    n = (osz == OSZ_16) ? 5'd4 : (osz == OSZ_32) ? 5'd6 : 5'd0;
         default: n = 5'd0;
      endcase
   end

   assign nbytes = ICW'(n);

endmodule

// File: rtl/ispl_le_acc.sv
module ispl_le_acc #(
   parameter int NB  = 4,
   parameter int CW  = $clog2(NB + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [7:0]        din,
   output logic [NB*8-1:0]   value,
   output logic [CW-1:0]     cnt
);

   logic [7:0]    lane_q [NB];
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (wr)   cnt_q <= cnt_q + CW'(1);
   end

   // R7: each lane takes the byte whose arrival index matches it
   for (genvar k = 0; k < NB; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       lane_q[k] <= '0;
         else if (clr)                     lane_q[k] <= '0;
         else if (wr && cnt_q == CW'(k))   lane_q[k] <= din;
      end
      assign value[8*k +: 8] = lane_q[k];
   end

   assign cnt = cnt_q;

   assert_acc_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (cnt_q < CW'(NB)));

endmodule

// File: rtl/insn_splitter.sv
module insn_splitter
   import ispl_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LW         = 8,
   parameter int DISP_BYTES = 4,
   parameter int IMM_BYTES  = 16,
   parameter int MAX_ESC    = 2,
   localparam int MW        = $clog2(MAX_ESC + 1)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_in,
   input  logic [AW-1:0]           byte_pc,
   output logic [MW-1:0]           tbl_map,
   input  logic                    tbl_modrm,
   input  logic [3:0]              tbl_itype,
   output logic                    rdy,
   output logic [LW-1:0]           ins_len,
   output logic [7:0]              ins_rex,
   output logic [MW-1:0]           ins_map,
   output logic [7:0]              ins_opc,
   output logic [7:0]              ins_modrm,
   output logic [7:0]              ins_sib,
   output logic [8*DISP_BYTES-1:0] ins_disp,
   output logic [8*IMM_BYTES-1:0]  ins_imm,
   output logic [1:0]              ins_osz
);

   localparam int DCW = $clog2(DISP_BYTES + 1);
   localparam int ICW = $clog2(IMM_BYTES + 1);

   if (DISP_BYTES != 4) begin : g_chk_disp
      $error("DISP_BYTES must be 4");
   end
   if (IMM_BYTES < 16) begin : g_chk_imm
      $error("IMM_BYTES must hold a 16-byte immediate");
   end
   if (LW < 4 || LW > AW) begin : g_chk_len
      $error("LW out of range");
   end
   if (MAX_ESC < 1) begin : g_chk_esc
      $error("MAX_ESC must be at least 1");
   end

   // state
   phase_e          st_q, n_st;
   logic [7:0]      rex_q, opc_q, mrm_q, sib_q;
   logic [7:0]      n_rex, n_opc, n_mrm, n_sib;
   logic            o66_q, n_o66;
   logic [MW-1:0]   map_q, n_map;
   osz_e            osz_q, n_osz;
   logic [ICW-1:0]  ineed_q, n_ineed;
   logic [2:0]      dneed_q, n_dneed;
   logic [AW-1:0]   start_q;
   logic            rdy_q;
   logic [LW-1:0]   len_q;

   // views with the per-instruction wipe applied
   logic            wipe;
   logic [7:0]      c_rex;
   logic            c_o66;
   logic [MW-1:0]   c_map;
   osz_e            c_osz;
   logic [AW-1:0]   c_start;
   logic [AW-1:0]   len_calc;

   logic            take_op, done, wr_d, wr_i;
   logic [2:0]      dsz;
   logic [1:0]      mod;
   logic [ICW-1:0]  op_isz;
   logic [DCW-1:0]  disp_cnt;
   logic [ICW-1:0]  imm_cnt;

   // R1: the first byte of an instruction arrives in the idle phase
   assign wipe = byte_vld && (st_q == S_RST);

   always_comb begin
      c_rex   = wipe ? '0 : rex_q;
      c_o66   = wipe ? 1'b0 : o66_q;
      c_map   = wipe ? '0 : map_q;
      c_start = wipe ? byte_pc : start_q;
      // R5: REX.W outranks the operand-size prefix
      if (c_rex[3])   c_osz = OSZ_64;
      else if (c_o66) c_osz = OSZ_16;
      else            c_osz = OSZ_32;
   end

   assign tbl_map = c_map;

   ispl_imm_size #(.ICW(ICW)) u_isz (
      .osz    (c_osz),
      .itype  (tbl_itype),
      .nbytes (op_isz)
   );

   assign mod = mrm_q[7:6];

   always_comb begin
      n_st    = st_q;
      n_rex   = c_rex;
      n_o66   = c_o66;
      n_map   = c_map;
      n_opc   = wipe ? '0 : opc_q;
      n_mrm   = wipe ? '0 : mrm_q;
      n_sib   = wipe ? '0 : sib_q;
      n_ineed = wipe ? '0 : ineed_q;
      n_dneed = wipe ? '0 : dneed_q;
      n_osz   = wipe ? OSZ_32 : osz_q;
      take_op = 1'b0;
      done    = 1'b0;
      wr_d    = 1'b0;
      wr_i    = 1'b0;
      dsz     = 3'd0;
      if (byte_vld) begin
         unique case (st_q)
            S_RST, S_PFX: begin
               // R2: prefixes keep the machine in the prefix phase
               if (is_rex(byte_in)) begin
                  n_rex = byte_in;
                  n_st  = S_PFX;
               end else if (is_legacy(byte_in)) begin
                  n_st = S_PFX;
                  if (byte_in == BYTE_OSZ) n_o66 = 1'b1;
               end else begin
                  take_op = 1'b1;
               end
            end
            S_OPC: take_op = 1'b1;
            S_MRM: begin
               // R4: displacement size and SIB presence from ModRM
               n_mrm = byte_in;
               if (byte_in[7:6] == 2'd1)                              dsz = 3'd1;
               else if (byte_in[7:6] == 2'd2)                         dsz = 3'd4;
               else if (byte_in[7:6] == 2'd0 && byte_in[2:0] == 3'd5) dsz = 3'd4;
               n_dneed = dsz;
               if (byte_in[7:6] != 2'd3 && byte_in[2:0] == 3'd4) n_st = S_SIB;
               else if (dsz != 3'd0)                             n_st = S_DSP;
               else if (ineed_q != '0)                           n_st = S_IMM;
               else                                              done = 1'b1;
            end
            S_SIB: begin
               n_sib = byte_in;
               if (mod == 2'd0 && byte_in[2:0] == 3'd5) n_dneed = 3'd4;
               if (n_dneed != 3'd0)      n_st = S_DSP;
               else if (ineed_q != '0)   n_st = S_IMM;
               else                      done = 1'b1;
            end
            S_DSP: begin
               wr_d = 1'b1;
               if (DCW'(disp_cnt + DCW'(1)) == DCW'(dneed_q)) begin
                  if (ineed_q != '0) n_st = S_IMM;
                  else               done = 1'b1;
               end
            end
            S_IMM: begin
               // R10: complete only on the last required byte
               wr_i = 1'b1;
               if (ICW'(imm_cnt + ICW'(1)) == ineed_q) done = 1'b1;
            end
            default: n_st = S_RST;
         endcase

         if (take_op) begin
            // R3: escape counting, then phase choice after the opcode
            if (byte_in == BYTE_ESC && c_map < MW'(MAX_ESC)) begin
               n_map = c_map + MW'(1);
               n_st  = S_OPC;
            end else begin
               n_opc   = byte_in;
               n_osz   = c_osz;
               n_ineed = op_isz;
               if (tbl_modrm)            n_st = S_MRM;
               else if (op_isz != '0)    n_st = S_IMM;
               else                      done = 1'b1;
            end
         end

         if (done) n_st = S_RST;
      end
   end

   assign len_calc = byte_pc - c_start + AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_RST;
         rex_q   <= '0;
         opc_q   <= '0;
         mrm_q   <= '0;
         sib_q   <= '0;
         o66_q   <= 1'b0;
         map_q   <= '0;
         osz_q   <= OSZ_32;
         ineed_q <= '0;
         dneed_q <= '0;
         start_q <= '0;
         rdy_q   <= 1'b0;
         len_q   <= '0;
      end else begin
         rdy_q <= done;
         if (byte_vld) begin
            st_q    <= n_st;
            rex_q   <= n_rex;
            opc_q   <= n_opc;
            mrm_q   <= n_mrm;
            sib_q   <= n_sib;
            o66_q   <= n_o66;
            map_q   <= n_map;
            osz_q   <= n_osz;
            ineed_q <= n_ineed;
            dneed_q <= n_dneed;
            if (wipe) start_q <= byte_pc;
            if (done) len_q   <= LW'(len_calc);
         end
      end
   end

   ispl_le_acc #(.NB(DISP_BYTES), .CW(DCW)) u_disp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wipe),
      .wr    (wr_d),
      .din   (byte_in),
      .value (ins_disp),
      .cnt   (disp_cnt)
   );

   ispl_le_acc #(.NB(IMM_BYTES), .CW(ICW)) u_imm (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wipe),
      .wr    (wr_i),
      .din   (byte_in),
      .value (ins_imm),
      .cnt   (imm_cnt)
   );

   assign rdy       = rdy_q;
   assign ins_len   = len_q;
   assign ins_rex   = rex_q;
   assign ins_map   = map_q;
   assign ins_opc   = opc_q;
   assign ins_modrm = mrm_q;
   assign ins_sib   = sib_q;
   assign ins_osz   = osz_q;

   assert_ready_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> $past(byte_vld));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> ($stable(st_q) && !rdy_q));

   assert_imm_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> (imm_cnt == ineed_q));

   assert_disp_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> (disp_cnt == DCW'(dneed_q)));

   assert_disp_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dneed_q == 3'd0) || (dneed_q == 3'd1) || (dneed_q == 3'd4));

endmodule

// File: tb/sim_insn_splitter.sv
module sim_insn_splitter;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [127:0] b;
      logic [4:0]   n;
      logic [7:0]   rex;
      logic [1:0]   map;
      logic [7:0]   opc;
      logic [7:0]   mrm;
      logic [7:0]   sib;
      logic [31:0]  disp;
      logic [63:0]  imm;
      logic [1:0]   osz;
      logic [7:0]   len;
   } vec_t;

   // bytes are packed first byte lowest
   localparam vec_t TAB [21] = '{
      '{128'h10,                   5'd1,  8'h00, 2'd0, 8'h10, 8'h00, 8'h00, 32'h0,        64'h0,                 2'd1, 8'd1},
      '{128'hBBAA12,               5'd3,  8'h00, 2'd0, 8'h12, 8'h00, 8'h00, 32'h0,        64'hBBAA,              2'd1, 8'd3},
      '{128'h4433221113,           5'd5,  8'h00, 2'd0, 8'h13, 8'h00, 8'h00, 32'h0,        64'h44332211,          2'd1, 8'd5},
      '{128'h08070605040302011648, 5'd10, 8'h48, 2'd0, 8'h16, 8'h00, 8'h00, 32'h0,        64'h0807060504030201,  2'd2, 8'd10},
      '{128'h12341666,             5'd4,  8'h00, 2'd0, 8'h16, 8'h00, 8'h00, 32'h0,        64'h1234,              2'd0, 8'd4},
      '{128'hAABBCCDD17,           5'd5,  8'h00, 2'd0, 8'h17, 8'h00, 8'h00, 32'h0,        64'hAABBCCDD,          2'd1, 8'd5},
      '{128'h010203041748,         5'd6,  8'h48, 2'd0, 8'h17, 8'h00, 8'h00, 32'h0,        64'h01020304,          2'd2, 8'd6},
      '{128'h1948,                 5'd2,  8'h48, 2'd0, 8'h19, 8'h00, 8'h00, 32'h0,        64'h0,                 2'd2, 8'd2},
      '{128'hC3B2A118,             5'd4,  8'h00, 2'd0, 8'h18, 8'h00, 8'h00, 32'h0,        64'hC3B2A1,            2'd1, 8'd4},
      '{128'hC080,                 5'd2,  8'h00, 2'd0, 8'h80, 8'hC0, 8'h00, 32'h0,        64'h0,                 2'd1, 8'd2},
      '{128'h7F4580,               5'd3,  8'h00, 2'd0, 8'h80, 8'h45, 8'h00, 32'h7F,       64'h0,                 2'd1, 8'd3},
      '{128'h123456780580,         5'd6,  8'h00, 2'd0, 8'h80, 8'h05, 8'h00, 32'h12345678, 64'h0,                 2'd1, 8'd6},
      '{128'hDEADBEEF250480,       5'd7,  8'h00, 2'd0, 8'h80, 8'h04, 8'h25, 32'hDEADBEEF, 64'h0,                 2'd1, 8'd7},
      '{128'h08244480,             5'd4,  8'h00, 2'd0, 8'h80, 8'h44, 8'h24, 32'h08,       64'h0,                 2'd1, 8'd4},
      '{128'h9C04030201888481,     5'd8,  8'h00, 2'd0, 8'h81, 8'h84, 8'h88, 32'h04030201, 64'h9C,                2'd1, 8'd8},
      '{128'hC1100F,               5'd3,  8'h00, 2'd1, 8'h10, 8'hC1, 8'h00, 32'h0,        64'h0,                 2'd1, 8'd3},
      '{128'h5A200F0F,             5'd4,  8'h00, 2'd2, 8'h20, 8'h00, 8'h00, 32'h0,        64'h5A,                2'd1, 8'd4},
      '{128'h0201122EF3,           5'd5,  8'h00, 2'd0, 8'h12, 8'h00, 8'h00, 32'h0,        64'h0201,              2'd1, 8'd5},
      '{128'h104C41,               5'd3,  8'h4C, 2'd0, 8'h10, 8'h00, 8'h00, 32'h0,        64'h0,                 2'd2, 8'd3},
      '{128'h44332211174866,       5'd7,  8'h48, 2'd0, 8'h17, 8'h00, 8'h00, 32'h0,        64'h44332211,          2'd2, 8'd7},
      '{128'hC480,                 5'd2,  8'h00, 2'd0, 8'h80, 8'hC4, 8'h00, 32'h0,        64'h0,                 2'd1, 8'd2}
   };

   logic          clk;
   logic          rst_n;
   logic          byte_vld;
   logic [7:0]    byte_in;
   logic [31:0]   byte_pc;
   logic [1:0]    tbl_map;
   logic          tbl_modrm;
   logic [3:0]    tbl_itype;
   logic          rdy;
   logic [7:0]    ins_len;
   logic [7:0]    ins_rex;
   logic [1:0]    ins_map;
   logic [7:0]    ins_opc;
   logic [7:0]    ins_modrm;
   logic [7:0]    ins_sib;
   logic [31:0]   ins_disp;
   logic [127:0]  ins_imm;
   logic [1:0]    ins_osz;

   int            total = 0;
   int            bad = 0;
   bit            finished = 0;
   logic [31:0]   pc = 32'h1000;

   insn_splitter u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_in   (byte_in),
      .byte_pc   (byte_pc),
      .tbl_map   (tbl_map),
      .tbl_modrm (tbl_modrm),
      .tbl_itype (tbl_itype),
      .rdy       (rdy),
      .ins_len   (ins_len),
      .ins_rex   (ins_rex),
      .ins_map   (ins_map),
      .ins_opc   (ins_opc),
      .ins_modrm (ins_modrm),
      .ins_sib   (ins_sib),
      .ins_disp  (ins_disp),
      .ins_imm   (ins_imm),
      .ins_osz   (ins_osz)
   );

   // bench-side opcode lookup
   always_comb begin
      case (tbl_map)
         2'd0: begin tbl_modrm = byte_in[7]; tbl_itype = byte_in[3:0]; end
         2'd1: begin tbl_modrm = 1'b1;       tbl_itype = 4'd0;         end
         default: begin tbl_modrm = 1'b0;    tbl_itype = 4'd1;         end
      endcase
   end

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      byte_vld = 1'b1;
      byte_in  = b;
      byte_pc  = pc;
      @(posedge clk);
      #1;
      byte_vld = 1'b0;
      pc = pc + 32'd1;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic early;
      rst_n    = 1'b0;
      byte_vld = 1'b0;
      byte_in  = 8'h00;
      byte_pc  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R1: reset state
      chk("R1", "rdy after reset", rdy, 0);
      chk("R1", "len after reset", ins_len, 0);
      chk("R1", "opc after reset", ins_opc, 0);
      chk("R1", "imm after reset", ins_imm, 0);
      chk("R1", "disp after reset", ins_disp, 0);

      // vector table
      foreach (TAB[i]) begin
         early = 1'b0;
         for (int k = 0; k < int'(TAB[i].n); k++) begin
            put(TAB[i].b[8*k +: 8]);
            if (k < int'(TAB[i].n) - 1 && rdy) early = 1'b1;
         end
         chk("R8",  $sformatf("v%0d rdy", i),   rdy, 1);
         chk("R10", $sformatf("v%0d early", i), early, 0);
         chk("R8",  $sformatf("v%0d len", i),   ins_len, TAB[i].len);
         chk("R2",  $sformatf("v%0d rex", i),   ins_rex, TAB[i].rex);
         chk("R3",  $sformatf("v%0d map", i),   ins_map, TAB[i].map);
         chk("R3",  $sformatf("v%0d opc", i),   ins_opc, TAB[i].opc);
         chk("R4",  $sformatf("v%0d modrm", i), ins_modrm, TAB[i].mrm);
         chk("R4",  $sformatf("v%0d sib", i),   ins_sib, TAB[i].sib);
         chk("R7",  $sformatf("v%0d disp", i),  ins_disp, TAB[i].disp);
         chk("R6",  $sformatf("v%0d imm", i),   ins_imm, {64'h0, TAB[i].imm});
         chk("R5",  $sformatf("v%0d osz", i),   ins_osz, TAB[i].osz);
      end

      // R9: idle gap in the middle of an immediate
      put(8'h13); put(8'h11); put(8'h22);
      early = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk);
         #1;
         if (rdy) early = 1'b1;
      end
      chk("R9", "rdy during gap", early, 0);
      put(8'h33); put(8'h44);
      chk("R9", "rdy after gap", rdy, 1);
      chk("R9", "imm after gap", ins_imm, 128'h44332211);
      chk("R9", "len after gap", ins_len, 5);

      // R8: back-to-back single-byte instructions, then a one-cycle flag
      put(8'h10);
      chk("R8", "first single rdy", rdy, 1);
      put(8'h10);
      chk("R8", "second single rdy", rdy, 1);
      chk("R8", "second single len", ins_len, 1);
      @(posedge clk);
      #1;
      chk("R8", "rdy drops after one cycle", rdy, 0);

      // R1: fields of the previous instruction are wiped
      put(8'h48); put(8'h80); put(8'h04); put(8'h25);
      put(8'h01); put(8'h02); put(8'h03); put(8'h04);
      chk("R1", "setup rdy", rdy, 1);
      put(8'h10);
      chk("R1", "wiped modrm", ins_modrm, 0);
      chk("R1", "wiped sib", ins_sib, 0);
      chk("R1", "wiped disp", ins_disp, 0);
      chk("R1", "wiped rex", ins_rex, 0);
      chk("R1", "wiped osz", ins_osz, 1);

      // R6 / R10: sixteen-byte immediate
      put(8'h15);
      for (int k = 0; k < 15; k++) put(8'(k + 1));
      chk("R10", "rdy before last imm byte", rdy, 0);
      put(8'h10);
      chk("R10", "rdy on last imm byte", rdy, 1);
      chk("R6", "oword imm", ins_imm, 128'h100F0E0D0C0B0A090807060504030201);
      chk("R7", "oword len", ins_len, 17);

      // R3: escape limit reached, 0x0F becomes the opcode
      put(8'h0F); put(8'h0F); put(8'h0F); put(8'h77);
      chk("R3", "escape cap opc", ins_opc, 8'h0F);
      chk("R3", "escape cap map", ins_map, 2);
      chk("R3", "escape cap imm", ins_imm, 128'h77);
      chk("R3", "escape cap len", ins_len, 4);

      // R8: length across an address wrap
      pc = 32'hFFFF_FFFE;
      put(8'h12); put(8'h01); put(8'h02);
      chk("R8", "wrap len", ins_len, 3);
      chk("R8", "wrap rdy", rdy, 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule